// File: doc/BRIEF.md
# RAM-Based Circular Delay Line

This block builds a long, word-wide shift register out of one synchronous memory array instead of a chain of flip-flops, so that a line thousands of stages deep fits in block RAM. Nothing in the array moves. A head pointer marks the slot that takes the next input word. A tail pointer marks the slot whose word leaves next. Both pointers step forward together, once for each accepted sample.

The block is driven by a single sample clock, and all of its state changes on the falling edge of that clock. A shift-enable input gates every change. When shift-enable is high, one input word is accepted, the oldest word is presented on the output, and both pointers advance. When shift-enable is low, everything holds.

An optional synchronous active-low reset puts the two pointers back at their start positions. It never touches the stored words, so the memory keeps only a clock and a clock enable. For the first LENGTH-1 accepted samples after start-up, the output is undefined.

Top module: `ram_delay_line`

## Requirements
- R1: On the falling clock edge where shift-enable is high and reset is released, counting that edge as the k-th accepted edge since reset (k from 0), `dout` changes to the `din` word accepted on accepted edge k-(LENGTH-1). The line therefore acts as a LENGTH-stage shift register whose last stage drives `dout`, and `dout` is defined once k >= LENGTH-1.
- R2: On a falling edge with shift-enable low, `dout`, the stored words and both pointers keep their values. Idle gaps of any length do not count as samples and do not disturb the delay of R1.
- R3: `din`, `shift_en` and `rst_n` are sampled on the falling edge of `clk`. A value changed just after a rising edge is the value that takes effect.
- R4: The head and tail pointers count modulo LENGTH. Each increments by one on an accepted edge and wraps from LENGTH-1 to 0. Both always stay below LENGTH. The tail always sits one slot ahead of the head, modulo LENGTH.
- R5: A falling edge with `rst_n` low sets the head pointer to LENGTH-1 and the tail pointer to 0.
- R6: Reset does not clear the stored words. If reset is applied after a whole multiple of LENGTH accepted samples, the pointers already sit at their reset positions, and the output stream continues without interruption as if no reset had occurred.
- R7: While `rst_n` is low, no sample is accepted even when shift-enable is high, and `dout` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset of the two pointers only |
| shift_en | input | 1 | Accept one sample and advance the line on this edge |
| din | input | DATA_W | Word entering the line |
| dout | output | DATA_W | Word leaving the line (registered memory read) |

## Verification
The bench builds the line with DATA_W = 8 and LENGTH = 5. A length this short means the pointers wrap dozens of times in a few hundred cycles. It also makes it cheap to drive every 5-cycle on/off enable pattern in turn, and to land a reset exactly on a multiple of LENGTH accepted samples, where the stored contents must carry straight across the reset. Expected words come from an arithmetic data sequence held in a software queue of depth LENGTH. Inputs change just after the rising edge, so a design that sampled on the wrong edge would pick up stale words.

// File: rtl/dl_pkg.sv
// Package: dl_pkg
// Shared helpers for the RAM-based delay line.
// Assumes: depths are positive integers.
package dl_pkg;

    // Address width needed to index 'depth' slots (never below one bit).
    function automatic int ptr_w(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/dl_mod_counter.sv
// Module: dl_mod_counter
// Modulo-MOD address counter with a preload value. On a falling clock
// edge it loads PRELOAD when rst_n is low. Otherwise it steps by one when
// adv is high, and wraps from MOD-1 to 0.
// Assumes: MOD >= 2, PRELOAD < MOD, AW wide enough to hold MOD-1.
module dl_mod_counter #(
    parameter int MOD     = 8,
    parameter int PRELOAD = 0,
    parameter int AW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] cnt
);

    localparam logic [AW-1:0] LAST = AW'(MOD - 1);
    localparam logic [AW-1:0] INIT = AW'(PRELOAD);

    // Reset to the preload value, else advance with wrap.
    always_ff @(negedge clk) begin
        if (!rst_n)
            cnt <= INIT;
        else if (adv)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/dl_ram.sv
// Module: dl_ram
// Simple dual-address synchronous RAM on the falling clock edge, with
// one clock enable and no reset, so that it infers block memory.
// The read is registered and returns the word held before a write to
// the same address on the same edge.
// Assumes: both addresses are below DEPTH.
module dl_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          ce,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    // Read old data, then write, both gated by the single clock enable.
    always_ff @(negedge clk) begin
        if (ce) begin
            rd_data       <= mem[rd_addr];
            mem[wr_addr]  <= wr_data;
        end
    end

endmodule

// File: rtl/ram_delay_line.sv
// Module: ram_delay_line
// LENGTH-stage, DATA_W-wide shift register built as a circular buffer
// in one inferred RAM. The head counter (preload LENGTH-1) addresses
// writes. The tail counter (preload 0) addresses reads, one slot ahead
// of the head. With the registered read this gives the delay of a
// LENGTH-stage register chain.
// Assumes: LENGTH >= 2. Storage is never reset; output is undefined
// until LENGTH-1 samples have been accepted after start-up.
module ram_delay_line #(
    parameter int DATA_W = 16,
    parameter int LENGTH = 2678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int AW = dl_pkg::ptr_w(LENGTH);

    logic [AW-1:0] head_ptr;
    logic [AW-1:0] tail_ptr;
    logic          mem_ce;

    // Storage clock enable: accept only when enabled and out of reset.
    always_comb mem_ce = shift_en & rst_n;

    dl_mod_counter #(.MOD(LENGTH), .PRELOAD(LENGTH - 1), .AW(AW)) u_head (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .cnt   (head_ptr)
    );

    dl_mod_counter #(.MOD(LENGTH), .PRELOAD(0), .AW(AW)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (shift_en),
        .cnt   (tail_ptr)
    );

    dl_ram #(.W(DATA_W), .DEPTH(LENGTH), .AW(AW)) u_ram (
        .clk     (clk),
        .ce      (mem_ce),
        .wr_addr (head_ptr),
        .wr_data (din),
        .rd_addr (tail_ptr),
        .rd_data (dout)
    );

endmodule

// File: rtl/ram_delay_line_chk.sv
// Module: ram_delay_line_chk
// Property checker bound into ram_delay_line. It watches the pointers
// and the output word on the falling clock edge.
// Assumes: LENGTH >= 2, rst_n held low at time zero.
module ram_delay_line_chk #(
    parameter int DATA_W = 16,
    parameter int LENGTH = 2678
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            shift_en,
    input logic [DATA_W-1:0]               dout,
    input logic [dl_pkg::ptr_w(LENGTH)-1:0] head_ptr,
    input logic [dl_pkg::ptr_w(LENGTH)-1:0] tail_ptr
);

    localparam int AW = dl_pkg::ptr_w(LENGTH);
    localparam logic [AW-1:0] LAST = AW'(LENGTH - 1);

    logic [AW-1:0] head_succ;

    // Successor slot of the head pointer, used to relate the two counters.
    always_comb head_succ = (head_ptr == LAST) ? '0 : head_ptr + 1'b1;

    // R4
    head_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (head_ptr <= LAST) && (tail_ptr <= LAST));

    // R4
    tail_lead_chk: assert property (@(negedge clk) disable iff (!rst_n)
        tail_ptr == head_succ);

    // R4
    head_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
        shift_en |=> head_ptr == $past(head_succ));

    // R2
    idle_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(head_ptr) && $stable(tail_ptr) && $stable(dout));

    // R5
    reset_ptr_chk: assert property (@(negedge clk)
        !rst_n |=> (head_ptr == LAST) && (tail_ptr == '0));

    // R7
    reset_dout_chk: assert property (@(negedge clk)
        (!rst_n && $past(!rst_n)) |=> $stable(dout));

endmodule

bind ram_delay_line ram_delay_line_chk #(.DATA_W(DATA_W), .LENGTH(LENGTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .dout     (dout),
    .head_ptr (head_ptr),
    .tail_ptr (tail_ptr)
);

// File: tb/ram_delay_line_tb.sv
`timescale 1ns/1ps
module ram_delay_line_tb;

    localparam int W = 8;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    int n_tests = 0;
    int n_fail  = 0;
    int seq     = 0;
    int accepted = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] prev_dout;
    bit           prev_known = 1'b0;

    always #2.5 clk = ~clk;

    ram_delay_line #(.DATA_W(W), .LENGTH(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (din),
        .dout     (dout)
    );

    task automatic check(input bit ok, input string req,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: dout=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One sample period: drive just after a rising edge, let the falling
    // edge act, then compare at the next rising edge (R3).
    task automatic cycle(input bit en, input bit rst);
        logic [W-1:0] d;
        logic [W-1:0] exp;
        d = W'(seq * 73 + 5);
        seq++;
        #1;
        shift_en = en;
        din      = d;
        rst_n    = !rst;
        @(negedge clk);
        @(posedge clk);
        if (rst) begin
            // R7: reset freezes the output
            if (prev_known) check(dout === prev_dout, "R7", dout, prev_dout);
            // R6: aligned reset keeps the stream; otherwise warm up again
            if (accepted % N != 0) begin
                q.delete();
                prev_known = 1'b0;
            end
            accepted = 0;
        end else if (en) begin
            q.push_back(d);
            accepted++;
            if (q.size() > N) void'(q.pop_front());
            if (q.size() == N) begin
                exp = q[0];
                // R1 R3 R4 R6: word from LENGTH-1 accepted edges back
                check(dout === exp, "R1", dout, exp);
                prev_dout  = dout;
                prev_known = 1'b1;
            end else begin
                prev_known = 1'b0;
            end
        end else begin
            // R2: idle edge holds the output
            if (prev_known) check(dout === prev_dout, "R2", dout, prev_dout);
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk);
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1);   // R5 R7 start-up reset
        // R1 R4: back-to-back across several wraps
        for (int i = 0; i < 3 * N + 2; i++) cycle(1'b1, 1'b0);
        // R2: every 5-cycle enable pattern
        for (int p = 0; p < 32; p++)
            for (int b = 0; b < 5; b++) cycle(p[b], 1'b0);
        // R2: long idle gap, then resume
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0);
        for (int i = 0; i < 2 * N; i++) cycle(1'b1, 1'b0);
        // R6: reset on a multiple of LENGTH keeps the stream intact
        while (accepted % N != 0) cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b1);
        for (int i = 0; i < 2 * N; i++) cycle(1'b1, 1'b0);
        // R5: misaligned reset, warm-up, then delay re-established
        cycle(1'b1, 1'b0);
        if (accepted % N == 0) cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        for (int i = 0; i < 3 * N; i++) cycle(1'b1, 1'b0);
        // R1 R2 R4: mixed random enables
        for (int i = 0; i < 300; i++) cycle(($urandom % 4) != 0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule